// File: doc/BRIEF.md
# Multi-Mask Exact-Match Classifier

This block classifies a search key against the rule set of a single region. It does not run one ternary search over the whole rule table. Instead it keeps a small set of region masks and runs a series of exact-match probes, one mask per clock cycle:

- The key is ANDed with the current mask.
- The result is compared against every stored rule tagged with that mask.
- The best hit by priority is kept.

A stored rule can carry a skip list of masks. When the rule hits, those masks are dropped from the rest of the lookup. A rule can also carry a flag that, when it belongs to the winning hit, suppresses the final search of a small ternary overflow table. The overflow table holds rules that could not be given a mask of their own.

Software loads masks, rules and overflow entries through a single write-style port. The same port also deletes and updates entries. Keys arrive on a valid/ready port, and each accepted key produces one result pulse. The pulse carries a hit flag, a no-match flag and the winning action pointer.

Top module: `mmx_classifier`

## Requirements
- R1: A rule hits in a probe when its mask slot is active, its mask id equals the probed slot, and its stored key equals the search key ANDed with that slot's mask. A mask bit of 1 compares the key bit and a bit of 0 ignores it. A rule tagged with an inactive slot never hits.
- R2: The largest 24-bit priority wins. When priorities are equal, the earlier hit wins. Slots are probed in ascending index order, and within one slot the lower rule index wins.
- R3: Active slots are probed in ascending order. After each probe, the skip lists of all rules that hit in it are ORed into a running skip set (bit n means slot n). A slot in that set is not probed.
- R4: After the mask probes, the overflow table is searched unless the winning hit has its overflow-skip flag set. An overflow entry matches when ((key XOR entry key) AND entry mask) is zero, and the lowest matching index is taken. That entry replaces the current best only if its priority is strictly larger.
- R5: Let P be the number of probes and S be 1 if the overflow search runs, else 0. `res_valid` is high for exactly one cycle, P+S clock edges after the edge that accepts the key. With no active slot, P is 0 and S is 1.
- R6: `key_ready` is low from the accepting edge until the result cycle. A key offered while it is low is ignored.
- R7: When nothing hits, the result has `res_hit`=0, `res_miss`=1 and `res_action`=0. On a hit, `res_miss`=0 and `res_action` is the winner's action pointer.
- R8: A plain write (`cfg_update`=0) with `cfg_entry_valid`=1 installs the entry if the slot is empty. If the slot is occupied, the write is ignored.
- R9: A plain write with `cfg_entry_valid`=0 deletes the entry at that slot.
- R10: An update (`cfg_update`=1) replaces the fields of an occupied slot and leaves it valid. An update to an empty slot is ignored.
- R11: After reset, every table is empty, `key_ready`=1 and `res_valid`=0.
- R12: `cfg_table` selects the target table. 0 selects the mask table (`cfg_index` is the slot, `cfg_mask` is the mask). 1 selects the rule table. 2 selects the overflow table (`cfg_key` and `cfg_mask` are used). Indices beyond a table's depth are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_table | input | 2 | Target table (0 mask, 1 rule, 2 overflow) |
| cfg_update | input | 1 | 1 = update existing entry, 0 = plain write |
| cfg_index | input | IDX_W | Entry index in the target table |
| cfg_entry_valid | input | 1 | Valid bit for plain writes (0 deletes) |
| cfg_key | input | KEY_W | Rule or overflow key |
| cfg_mask | input | KEY_W | Slot mask or overflow mask |
| cfg_erp | input | ERP_W | Mask slot a rule belongs to |
| cfg_prio | input | PRIO_W | Rule priority |
| cfg_prune | input | NUM_ERP | Rule skip list, one bit per slot |
| cfg_prune_spill | input | 1 | Rule overflow-skip flag |
| cfg_action | input | ACT_W | Action pointer |
| key_valid | input | 1 | Search key offered |
| key_in | input | KEY_W | Search key |
| key_ready | output | 1 | Engine idle, key accepted when valid |
| res_valid | output | 1 | One-cycle result pulse |
| res_hit | output | 1 | A rule or overflow entry won |
| res_miss | output | 1 | Nothing matched |
| res_action | output | ACT_W | Winning action pointer, 0 on miss |

## Verification
A corrupted skip set or a wrong probe order changes the cycle count from acceptance to `res_valid`. It can also let a shadowed rule win and change the action pointer. Both show on the very lookup that follows the fault. A table write that lands wrongly, such as an ignored write taking effect or a delete leaving a valid bit set, only shows on the next lookup whose key selects that entry. The bench therefore sweeps a grid of keys through every slot after each change to the tables. It compares the hit, the action and the latency against a model written from the requirements.

// File: rtl/mmx_pkg.sv
package mmx_pkg;

    typedef enum logic [1:0] {
        TBL_MASK  = 2'd0,
        TBL_RULE  = 2'd1,
        TBL_SPILL = 2'd2
    } tbl_e;

    typedef enum logic [1:0] {
        WR_NONE  = 2'd0,
        WR_LOAD  = 2'd1,
        WR_CLEAR = 2'd2
    } wr_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_SPILL = 2'd2
    } st_e;

    // Decide what a configuration access does to one slot.
    function automatic wr_e wr_decide(input logic occupied,
                                      input logic update,
                                      input logic keep);
        if (update)
            return occupied ? WR_LOAD : WR_NONE;
        if (!keep)
            return WR_CLEAR;
        return occupied ? WR_NONE : WR_LOAD;
    endfunction

endpackage

// File: rtl/mmx_mask_bank.sv
module mmx_mask_bank
    import mmx_pkg::*;
#(
    parameter int KEY_W   = 16,
    parameter int NUM_ERP = 16,
    parameter int IDX_W   = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            wr_update,
    input  logic                            wr_keep,
    input  logic [IDX_W-1:0]                wr_index,
    input  logic [KEY_W-1:0]                wr_mask,
    output logic [NUM_ERP-1:0]              active_o,
    output logic [NUM_ERP-1:0][KEY_W-1:0]   masks_o
);
    localparam int EW = $clog2(NUM_ERP);

    typedef struct packed {
        logic [NUM_ERP-1:0]            active;
        logic [NUM_ERP-1:0][KEY_W-1:0] masks;
    } bank_t;

    bank_t          s_d, s_q;
    logic [EW-1:0]  idx;
    logic           sel;

    assign idx = wr_index[EW-1:0];
    assign sel = wr_en && (int'(wr_index) < NUM_ERP);

    always_comb begin
        s_d = s_q;
        if (sel) begin
            case (wr_decide(s_q.active[idx], wr_update, wr_keep))
                WR_LOAD: begin
                    s_d.active[idx] = 1'b1;
                    s_d.masks[idx]  = wr_mask;
                end
                WR_CLEAR: s_d.active[idx] = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active_o = s_q.active;
    assign masks_o  = s_q.masks;

    // Plain write into an occupied slot leaves the mask untouched
    assert_plain_occupied_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr_update && wr_keep && s_q.active[idx])
        |=> (s_q.masks[$past(idx)] == $past(s_q.masks[idx])));

    // Delete clears the slot
    assert_delete_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr_update && !wr_keep) |=> !s_q.active[$past(idx)]);

    // Update to an empty slot does not create it
    assert_update_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_update && !s_q.active[idx]) |=> !s_q.active[$past(idx)]);

endmodule

// File: rtl/mmx_rule_bank.sv
module mmx_rule_bank
    import mmx_pkg::*;
#(
    parameter int KEY_W     = 16,
    parameter int NUM_ERP   = 16,
    parameter int NUM_RULES = 8,
    parameter int PRIO_W    = 24,
    parameter int ACT_W     = 8,
    parameter int IDX_W     = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         wr_update,
    input  logic                         wr_keep,
    input  logic [IDX_W-1:0]             wr_index,
    input  logic [KEY_W-1:0]             wr_key,
    input  logic [$clog2(NUM_ERP)-1:0]   wr_erp,
    input  logic [PRIO_W-1:0]            wr_prio,
    input  logic [NUM_ERP-1:0]           wr_prune,
    input  logic                         wr_prune_spill,
    input  logic [ACT_W-1:0]             wr_action,
    input  logic [$clog2(NUM_ERP)-1:0]   probe_erp,
    input  logic [KEY_W-1:0]             probe_key,
    output logic                         probe_hit,
    output logic [PRIO_W-1:0]            probe_prio,
    output logic [ACT_W-1:0]             probe_action,
    output logic                         probe_pspill,
    output logic [NUM_ERP-1:0]           probe_prune
);
    localparam int ERP_W = $clog2(NUM_ERP);
    localparam int RW    = $clog2(NUM_RULES);

    typedef struct packed {
        logic               valid;
        logic [KEY_W-1:0]   key;
        logic [ERP_W-1:0]   erp;
        logic [PRIO_W-1:0]  prio;
        logic [NUM_ERP-1:0] prune;
        logic               pspill;
        logic [ACT_W-1:0]   action;
    } rule_t;

    rule_t          rules_d [NUM_RULES];
    rule_t          rules_q [NUM_RULES];
    logic [RW-1:0]  idx;
    logic           sel;

    assign idx = wr_index[RW-1:0];
    assign sel = wr_en && (int'(wr_index) < NUM_RULES);

    always_comb begin
        for (int i = 0; i < NUM_RULES; i++) rules_d[i] = rules_q[i];
        if (sel) begin
            case (wr_decide(rules_q[idx].valid, wr_update, wr_keep))
                WR_LOAD:  rules_d[idx] = '{valid: 1'b1, key: wr_key, erp: wr_erp,
                                           prio: wr_prio, prune: wr_prune,
                                           pspill: wr_prune_spill, action: wr_action};
                WR_CLEAR: rules_d[idx].valid = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_RULES; i++) rules_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_RULES; i++) rules_q[i] <= rules_d[i];
        end
    end

    // Exact-match compare of every rule of the probed slot
    always_comb begin
        probe_hit    = 1'b0;
        probe_prio   = '0;
        probe_action = '0;
        probe_pspill = 1'b0;
        probe_prune  = '0;
        for (int i = 0; i < NUM_RULES; i++) begin
            if (rules_q[i].valid && rules_q[i].erp == probe_erp &&
                rules_q[i].key == probe_key) begin
                probe_prune = probe_prune | rules_q[i].prune;
                if (!probe_hit || rules_q[i].prio > probe_prio) begin
                    probe_hit    = 1'b1;
                    probe_prio   = rules_q[i].prio;
                    probe_action = rules_q[i].action;
                    probe_pspill = rules_q[i].pspill;
                end
            end
        end
    end

    // A plain write into an empty slot installs it
    assert_install_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr_update && wr_keep && !rules_q[idx].valid)
        |=> rules_q[$past(idx)].valid);

endmodule

// File: rtl/mmx_spill_bank.sv
module mmx_spill_bank
    import mmx_pkg::*;
#(
    parameter int KEY_W     = 16,
    parameter int NUM_SPILL = 4,
    parameter int PRIO_W    = 24,
    parameter int ACT_W     = 8,
    parameter int IDX_W     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_update,
    input  logic               wr_keep,
    input  logic [IDX_W-1:0]   wr_index,
    input  logic [KEY_W-1:0]   wr_key,
    input  logic [KEY_W-1:0]   wr_mask,
    input  logic [PRIO_W-1:0]  wr_prio,
    input  logic [ACT_W-1:0]   wr_action,
    input  logic [KEY_W-1:0]   search_key,
    output logic               search_hit,
    output logic [PRIO_W-1:0]  search_prio,
    output logic [ACT_W-1:0]   search_action
);
    localparam int SW = (NUM_SPILL > 1) ? $clog2(NUM_SPILL) : 1;

    typedef struct packed {
        logic              valid;
        logic [KEY_W-1:0]  key;
        logic [KEY_W-1:0]  mask;
        logic [PRIO_W-1:0] prio;
        logic [ACT_W-1:0]  action;
    } ent_t;

    ent_t           ent_d [NUM_SPILL];
    ent_t           ent_q [NUM_SPILL];
    logic [SW-1:0]  idx;
    logic           sel;

    assign idx = wr_index[SW-1:0];
    assign sel = wr_en && (int'(wr_index) < NUM_SPILL);

    always_comb begin
        for (int i = 0; i < NUM_SPILL; i++) ent_d[i] = ent_q[i];
        if (sel) begin
            case (wr_decide(ent_q[idx].valid, wr_update, wr_keep))
                WR_LOAD:  ent_d[idx] = '{valid: 1'b1, key: wr_key, mask: wr_mask,
                                         prio: wr_prio, action: wr_action};
                WR_CLEAR: ent_d[idx].valid = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SPILL; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_SPILL; i++) ent_q[i] <= ent_d[i];
        end
    end

    // Ternary search, lowest matching index taken
    always_comb begin
        search_hit    = 1'b0;
        search_prio   = '0;
        search_action = '0;
        for (int i = NUM_SPILL - 1; i >= 0; i--) begin
            if (ent_q[i].valid && (((search_key ^ ent_q[i].key) & ent_q[i].mask) == '0)) begin
                search_hit    = 1'b1;
                search_prio   = ent_q[i].prio;
                search_action = ent_q[i].action;
            end
        end
    end

    // Delete clears the entry
    assert_spill_delete_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr_update && !wr_keep) |=> !ent_q[$past(idx)].valid);

endmodule

// File: rtl/mmx_classifier.sv
module mmx_classifier
    import mmx_pkg::*;
#(
    parameter int KEY_W     = 16,
    parameter int NUM_ERP   = 16,
    parameter int NUM_RULES = 8,
    parameter int NUM_SPILL = 4,
    parameter int PRIO_W    = 24,
    parameter int ACT_W     = 8,
    parameter int IDX_W     = 4,
    parameter int ERP_W     = $clog2(NUM_ERP)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_valid,
    input  logic [1:0]         cfg_table,
    input  logic               cfg_update,
    input  logic [IDX_W-1:0]   cfg_index,
    input  logic               cfg_entry_valid,
    input  logic [KEY_W-1:0]   cfg_key,
    input  logic [KEY_W-1:0]   cfg_mask,
    input  logic [ERP_W-1:0]   cfg_erp,
    input  logic [PRIO_W-1:0]  cfg_prio,
    input  logic [NUM_ERP-1:0] cfg_prune,
    input  logic               cfg_prune_spill,
    input  logic [ACT_W-1:0]   cfg_action,
    input  logic               key_valid,
    input  logic [KEY_W-1:0]   key_in,
    output logic               key_ready,
    output logic               res_valid,
    output logic               res_hit,
    output logic               res_miss,
    output logic [ACT_W-1:0]   res_action
);
    typedef struct packed {
        st_e                st;
        logic [KEY_W-1:0]   key;
        logic [NUM_ERP-1:0] skip;
        logic               bhit;
        logic [PRIO_W-1:0]  bprio;
        logic [ACT_W-1:0]   bact;
        logic               bps;
        logic               rvalid;
        logic               rhit;
        logic [ACT_W-1:0]   ract;
    } eng_t;

    eng_t s_d, s_q;

    logic [NUM_ERP-1:0]            active;
    logic [NUM_ERP-1:0][KEY_W-1:0] masks;
    logic [ERP_W-1:0]              pick;
    logic [KEY_W-1:0]              probe_key;
    logic                          p_hit, p_ps, s_hit;
    logic [PRIO_W-1:0]             p_prio, s_prio;
    logic [ACT_W-1:0]              p_act, s_act;
    logic [NUM_ERP-1:0]            p_prune, elig;

    mmx_mask_bank #(.KEY_W(KEY_W), .NUM_ERP(NUM_ERP), .IDX_W(IDX_W)) mask_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_valid && cfg_table == TBL_MASK),
        .wr_update(cfg_update), .wr_keep(cfg_entry_valid),
        .wr_index(cfg_index), .wr_mask(cfg_mask),
        .active_o(active), .masks_o(masks)
    );

    mmx_rule_bank #(.KEY_W(KEY_W), .NUM_ERP(NUM_ERP), .NUM_RULES(NUM_RULES),
                    .PRIO_W(PRIO_W), .ACT_W(ACT_W), .IDX_W(IDX_W)) rule_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_valid && cfg_table == TBL_RULE),
        .wr_update(cfg_update), .wr_keep(cfg_entry_valid),
        .wr_index(cfg_index), .wr_key(cfg_key), .wr_erp(cfg_erp),
        .wr_prio(cfg_prio), .wr_prune(cfg_prune),
        .wr_prune_spill(cfg_prune_spill), .wr_action(cfg_action),
        .probe_erp(pick), .probe_key(probe_key),
        .probe_hit(p_hit), .probe_prio(p_prio), .probe_action(p_act),
        .probe_pspill(p_ps), .probe_prune(p_prune)
    );

    mmx_spill_bank #(.KEY_W(KEY_W), .NUM_SPILL(NUM_SPILL), .PRIO_W(PRIO_W),
                     .ACT_W(ACT_W), .IDX_W(IDX_W)) spill_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_valid && cfg_table == TBL_SPILL),
        .wr_update(cfg_update), .wr_keep(cfg_entry_valid),
        .wr_index(cfg_index), .wr_key(cfg_key), .wr_mask(cfg_mask),
        .wr_prio(cfg_prio), .wr_action(cfg_action),
        .search_key(s_q.key),
        .search_hit(s_hit), .search_prio(s_prio), .search_action(s_act)
    );

    // Lowest active slot not yet probed or pruned
    assign elig = active & ~s_q.skip;
    always_comb begin
        pick = '0;
        for (int i = NUM_ERP - 1; i >= 0; i--) begin
            if (elig[i]) pick = ERP_W'(i);
        end
    end
    assign probe_key = s_q.key & masks[pick];

    always_comb begin
        logic [NUM_ERP-1:0] skip_n;
        logic               finish;
        s_d      = s_q;
        s_d.rvalid = 1'b0;
        finish   = 1'b0;
        skip_n   = s_q.skip;
        case (s_q.st)
            ST_IDLE: begin
                if (key_valid) begin
                    s_d.key   = key_in;
                    s_d.skip  = '0;
                    s_d.bhit  = 1'b0;
                    s_d.bprio = '0;
                    s_d.bact  = '0;
                    s_d.bps   = 1'b0;
                    s_d.st    = (|active) ? ST_PROBE : ST_SPILL;
                end
            end
            ST_PROBE: begin
                if (p_hit && (!s_q.bhit || p_prio > s_q.bprio)) begin
                    s_d.bhit  = 1'b1;
                    s_d.bprio = p_prio;
                    s_d.bact  = p_act;
                    s_d.bps   = p_ps;
                end
                skip_n = s_q.skip | p_prune;
                skip_n[pick] = 1'b1;
                s_d.skip = skip_n;
                if ((active & ~skip_n) == '0) begin
                    if (s_d.bhit && s_d.bps) finish = 1'b1;
                    else                     s_d.st = ST_SPILL;
                end
            end
            ST_SPILL: begin
                if (s_hit && (!s_q.bhit || s_prio > s_q.bprio)) begin
                    s_d.bhit = 1'b1;
                    s_d.bact = s_act;
                end
                finish = 1'b1;
            end
            default: s_d.st = ST_IDLE;
        endcase
        if (finish) begin
            s_d.st     = ST_IDLE;
            s_d.rvalid = 1'b1;
            s_d.rhit   = s_d.bhit;
            s_d.ract   = s_d.bhit ? s_d.bact : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign key_ready  = (s_q.st == ST_IDLE);
    assign res_valid  = s_q.rvalid;
    assign res_hit    = s_q.rhit;
    assign res_miss   = s_q.rvalid && !s_q.rhit;
    assign res_action = s_q.ract;

    // Result is a single-cycle pulse
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // Engine is idle again when the result appears
    assert_ready_at_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> key_ready);

    // Accepted key makes the engine busy
    assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && key_ready) |=> !key_ready);

    // A probe cycle always has an active, unskipped slot to work on
    assert_probe_has_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_PROBE) |-> ((active & ~s_q.skip) != '0));

endmodule

// File: tb/mmx_classifier_tb_top.sv
module mmx_classifier_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic [1:0]  cfg_table = '0;
    logic        cfg_update = 1'b0;
    logic [3:0]  cfg_index = '0;
    logic        cfg_entry_valid = 1'b0;
    logic [15:0] cfg_key = '0;
    logic [15:0] cfg_mask = '0;
    logic [3:0]  cfg_erp = '0;
    logic [23:0] cfg_prio = '0;
    logic [15:0] cfg_prune = '0;
    logic        cfg_prune_spill = 1'b0;
    logic [7:0]  cfg_action = '0;
    logic        key_valid = 1'b0;
    logic [15:0] key_in = '0;
    logic        key_ready, res_valid, res_hit, res_miss;
    logic [7:0]  res_action;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmx_classifier dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_table(cfg_table),
        .cfg_update(cfg_update), .cfg_index(cfg_index),
        .cfg_entry_valid(cfg_entry_valid), .cfg_key(cfg_key), .cfg_mask(cfg_mask),
        .cfg_erp(cfg_erp), .cfg_prio(cfg_prio), .cfg_prune(cfg_prune),
        .cfg_prune_spill(cfg_prune_spill), .cfg_action(cfg_action),
        .key_valid(key_valid), .key_in(key_in), .key_ready(key_ready),
        .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
        .res_action(res_action)
    );

    // Shadow tables kept from the write rules
    bit        m_on [16];
    bit [15:0] m_val [16];
    bit        r_on [8];
    bit [15:0] r_key [8];
    bit [3:0]  r_erp [8];
    int        r_pri [8];
    bit [15:0] r_prn [8];
    bit        r_ps [8];
    bit [7:0]  r_act [8];
    bit        x_on [4];
    bit [15:0] x_key [4];
    bit [15:0] x_msk [4];
    int        x_pri [4];
    bit [7:0]  x_act [4];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Returns 1 when a slot of the given occupancy is loaded (R8 R10), -1 when cleared (R9)
    function automatic int decide(input bit occ, input bit upd, input bit ev);
        if (upd) return occ ? 1 : 0;
        if (!ev) return -1;
        return occ ? 0 : 1;
    endfunction

    task automatic cfg(input int tbl, input bit upd, input int idx, input bit ev,
                       input bit [15:0] k, input bit [15:0] m, input int erp,
                       input int pri, input bit [15:0] prn, input bit ps, input int act);
        int d;
        @(negedge clk);
        cfg_valid = 1; cfg_table = 2'(tbl); cfg_update = upd; cfg_index = 4'(idx);
        cfg_entry_valid = ev; cfg_key = k; cfg_mask = m; cfg_erp = 4'(erp);
        cfg_prio = 24'(pri); cfg_prune = prn; cfg_prune_spill = ps; cfg_action = 8'(act);
        @(negedge clk);
        cfg_valid = 0;
        if (tbl == 0 && idx < 16) begin
            d = decide(m_on[idx], upd, ev);
            if (d == 1) begin m_on[idx] = 1; m_val[idx] = m; end
            else if (d == -1) m_on[idx] = 0;
        end else if (tbl == 1 && idx < 8) begin
            d = decide(r_on[idx], upd, ev);
            if (d == 1) begin
                r_on[idx] = 1; r_key[idx] = k; r_erp[idx] = 4'(erp); r_pri[idx] = pri;
                r_prn[idx] = prn; r_ps[idx] = ps; r_act[idx] = 8'(act);
            end else if (d == -1) r_on[idx] = 0;
        end else if (tbl == 2 && idx < 4) begin
            d = decide(x_on[idx], upd, ev);
            if (d == 1) begin
                x_on[idx] = 1; x_key[idx] = k; x_msk[idx] = m; x_pri[idx] = pri;
                x_act[idx] = 8'(act);
            end else if (d == -1) x_on[idx] = 0;
        end
    endtask

    // Requirement model: R1 R2 R3 R4 R5
    task automatic model(input bit [15:0] k, output bit hit, output int act, output int lat);
        bit [15:0] skip = '0;
        bit        bh = 0, bps = 0;
        int        bp = 0, ba = 0, probes = 0;
        for (int e = 0; e < 16; e++) begin
            if (m_on[e] && !skip[e]) begin
                bit [15:0] orp = '0;
                bit        ph = 0, pps = 0;
                int        pp = 0, pa = 0;
                probes++;
                for (int r = 0; r < 8; r++) begin
                    if (r_on[r] && r_erp[r] == 4'(e) && r_key[r] == (k & m_val[e])) begin
                        orp |= r_prn[r];
                        if (!ph || r_pri[r] > pp) begin
                            ph = 1; pp = r_pri[r]; pa = r_act[r]; pps = r_ps[r];
                        end
                    end
                end
                if (ph && (!bh || pp > bp)) begin bh = 1; bp = pp; ba = pa; bps = pps; end
                skip |= orp;
            end
        end
        lat = probes;
        if (!(bh && bps)) begin
            lat++;
            for (int s = 0; s < 4; s++) begin
                if (x_on[s] && ((k ^ x_key[s]) & x_msk[s]) == 0) begin
                    if (!bh || x_pri[s] > bp) begin bh = 1; bp = x_pri[s]; ba = x_act[s]; end
                    break;
                end
            end
        end
        hit = bh;
        act = bh ? ba : 0;
    endtask

    task automatic lookup(input bit [15:0] k, input bit junk, input string req,
                          input bit use_exp, input int e_act, input int e_lat);
        bit mh; int ma, ml, cnt;
        model(k, mh, ma, ml);
        if (use_exp) begin
            check(ma == e_act, {req, " model action"}, ma, e_act);
            check(ml == e_lat, {req, " model latency"}, ml, e_lat);
        end
        @(negedge clk);
        while (!key_ready) @(negedge clk);
        key_valid = 1; key_in = k;
        @(posedge clk);
        @(negedge clk);
        key_valid = junk; key_in = ~k;
        cnt = 0;
        do begin
            @(posedge clk); cnt++;
            @(negedge clk);
        end while (!res_valid && cnt < 64);
        key_valid = 0;
        check(res_valid == 1'b1, {req, " R5 pulse"}, res_valid, 1);
        check(cnt == ml, {req, " R5 latency"}, cnt, ml);
        check(res_hit == mh && res_miss == !mh, {req, " R7 hit/miss"}, res_hit, mh);
        check(int'(res_action) == ma, {req, " action"}, res_action, ma);
        @(posedge clk);
        @(negedge clk);
        check(res_valid == 1'b0 && key_ready == 1'b1, {req, " R6 idle after result"},
              {res_valid, key_ready}, 1);
    endtask

    task automatic sweep(input string tag);
        bit [3:0] n3 [4] = '{4'h0, 4'h1, 4'h5, 4'hF};
        bit [3:0] n2 [3] = '{4'h0, 4'h2, 4'h6};
        bit [3:0] n1 [3] = '{4'h0, 4'h3, 4'hA};
        bit [3:0] n0 [2] = '{4'h0, 4'h4};
        int n = 0;
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 3; b++)
                for (int c = 0; c < 3; c++)
                    for (int d = 0; d < 2; d++) begin
                        lookup({n3[a], n2[b], n1[c], n0[d]}, n[0], {tag, " R1 R2 R3 R4"}, 0, 0, 0);
                        n++;
                    end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(key_ready == 1 && res_valid == 0, "R11 reset state", {key_ready, res_valid}, 2);
        // Empty tables: no slot probed, overflow only, miss
        lookup(16'h1234, 0, "R11 empty", 1, 0, 1);

        // Masks (R12 table 0)
        cfg(0, 0, 0, 1, 0, 16'hFF00, 0, 0, 0, 0, 0);
        cfg(0, 0, 1, 1, 0, 16'h00F0, 0, 0, 0, 0, 0);
        cfg(0, 0, 2, 1, 0, 16'h0F00, 0, 0, 0, 0, 0);
        cfg(0, 0, 3, 1, 0, 16'hFFFF, 0, 0, 0, 0, 0);
        cfg(0, 0, 5, 1, 0, 16'hF000, 0, 0, 0, 0, 0);
        // Rules
        cfg(1, 0, 0, 1, 16'h1200, 0, 0, 10, 0, 0, 1);
        cfg(1, 0, 1, 1, 16'h0030, 0, 1, 20, 0, 0, 2);
        cfg(1, 0, 2, 1, 16'h0200, 0, 2, 5, 16'h0008, 0, 3);
        cfg(1, 0, 3, 1, 16'h1234, 0, 3, 30, 0, 0, 4);
        cfg(1, 0, 4, 1, 16'h1000, 0, 5, 10, 0, 0, 5);
        cfg(1, 0, 5, 1, 16'h1200, 0, 0, 10, 0, 0, 6);
        cfg(1, 0, 6, 1, 16'h0000, 0, 4, 99, 0, 0, 7);
        cfg(1, 0, 7, 1, 16'h00A0, 0, 1, 15, 16'h0024, 1, 8);
        // Overflow entries
        cfg(2, 0, 0, 1, 16'h5600, 16'hFF00, 0, 25, 0, 0, 9);
        cfg(2, 0, 2, 1, 16'h0030, 16'h00FF, 0, 20, 0, 0, 11);
        // Out-of-range index ignored (R12)
        cfg(1, 0, 9, 1, 16'h0000, 0, 0, 200, 0, 0, 99);

        lookup(16'h1234, 0, "R3 prune hides slot 3", 1, 2, 5);
        lookup(16'h12A4, 1, "R4 overflow skipped by winner", 1, 8, 3);
        lookup(16'h0000, 0, "R7 no match, R1 inactive slot", 1, 0, 6);
        lookup(16'h1200, 1, "R2 equal priority ties", 1, 1, 5);
        lookup(16'h0030, 0, "R4 overflow tie keeps rule", 1, 2, 6);
        lookup(16'h5600, 0, "R4 overflow hit", 1, 9, 6);
        sweep("phase1");

        cfg(1, 0, 1, 1, 16'h0030, 0, 1, 50, 0, 0, 13);
        lookup(16'h0030, 0, "R8 plain write to occupied ignored", 1, 2, 6);
        cfg(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        lookup(16'h0030, 0, "R9 delete", 1, 11, 6);
        cfg(1, 1, 1, 1, 16'h0030, 0, 1, 50, 0, 0, 13);
        lookup(16'h0030, 1, "R10 update of empty ignored", 1, 11, 6);
        cfg(1, 1, 0, 1, 16'h1200, 0, 0, 40, 0, 0, 14);
        lookup(16'h1200, 0, "R10 update existing", 1, 14, 5);
        cfg(0, 0, 2, 0, 0, 0, 0, 0, 0, 0, 0);
        cfg(0, 1, 5, 1, 0, 16'hFF00, 0, 0, 0, 0, 0);
        cfg(0, 0, 4, 1, 0, 16'h00FF, 0, 0, 0, 0, 0);
        cfg(2, 0, 3, 1, 16'h0000, 16'h0000, 0, 1, 0, 0, 10);
        sweep("phase2");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule